// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one decrementing timer channel. It counts on a tick from a prescaler that divides the peripheral clock by 1, 16 or 256. The count width is 16 or 32 bits. The channel runs in one of three ways:

- **free-running**: it wraps to all ones for the current width;
- **periodic**: it reloads from a load register;
- **one-shot**: it halts at zero.

Software-side logic drives the channel through single-cycle write strobes that share one data bus. The strobes write the control word, the immediate load, the background load, and the interrupt clear. The outputs are the count, the load value, the control word, and a raw and a masked interrupt flag.

Both the count and the load are always kept at 32 bits. In 16-bit mode only the low half takes part in counting, so the upper halves survive any switch between widths. The two load strobes differ in timing:

- the immediate load replaces both the limit and the count in the same cycle;
- the background load changes only the limit, which is used at the next reload.

Top module: `dtimer`

## Requirements
- R1: After reset, ctrl_o is 0x00000020 (interrupt enable only), load_o is 0, count_o is 0xFFFFFFFF, and ris_o and mis_o are 0. The channel is stopped, in 16-bit free-running mode.
- R2: The control word layout is:
  - bit 0: one-shot;
  - bit 1: width (1 = 32-bit);
  - bits 3:2: prescale code;
  - bit 5: interrupt enable;
  - bit 6: mode (1 = periodic);
  - bit 7: enable.

  A control write stores wdata_i & 0xEF, so every other bit of ctrl_o reads 0.
- R3: With prescale code 0, 1 or 2 the count steps once every 1, 16 or 256 clocks. Code 3 behaves like code 2. After the edge that captures an enabling control write, the first step happens on the D-th following edge, where D is the divisor.
- R4: In free-running mode, a tick while the active low part is zero sets that part to all ones for the width (0xFFFF or 0xFFFFFFFF). This wrap does not set the interrupt.
- R5: In periodic mode, a tick while the active low part is zero reloads that part from the load register. The zero value therefore lasts one full tick period.
- R6: In 16-bit mode only bits 15:0 of the count change. Bits 31:16 of the count and of the load keep their stored values, and in 32-bit mode a decrement borrows across bit 16.
- R7: The immediate load strobe sets load_o and count_o to wdata_i on the next edge. The background load strobe sets only load_o.
- R8: In periodic mode, an immediate load whose active low part is zero stops counting. An immediate load with a nonzero active part while enable is set starts counting.
- R9: ris_o is set only when a tick decrements the active part to zero. It is cleared by the interrupt-clear strobe, and a set in the same cycle wins over the clear. mis_o is ris_o AND the interrupt-enable bit.
- R10: In one-shot mode the channel halts when it decrements to zero and holds zero. A control write with enable set restarts it, even if enable was already set.
- R11: A control write that changes the prescale field, including a change from 2 to 3, restarts the divider. The first step then comes a full divided period after that write.
- R12: A tick that falls in the same cycle as a control write or an immediate load is discarded and does not move the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| load_we_i | input | 1 | Immediate load write strobe |
| bgload_we_i | input | 1 | Background load write strobe |
| intclr_we_i | input | 1 | Interrupt clear strobe |
| wdata_i | input | 32 | Write data shared by all strobes |
| count_o | output | 32 | Current count, full 32 bits |
| load_o | output | 32 | Load register |
| ctrl_o | output | 32 | Control word, unused bits zero |
| ris_o | output | 1 | Raw interrupt status |
| mis_o | output | 1 | Masked interrupt status |

## Verification
The bench targets these timing and state corner cases:

- **Width switch:** a 16-bit count with a nonzero upper half must wrap back into the same upper half. A design that masked the whole word would clear it.
- **Divider restart:** a change of divider from 16 to 256 partway through a period must restart the divider. Without the restart, the first step arrives early.
- **One-shot restart:** a halted one-shot counter revived by a second identical control write must reload. A design that only starts on an enable edge stays stuck at zero.
- **Same-cycle events:** a clear that coincides with the decrement to zero must leave the flag set, and a load that coincides with a tick must land unmodified. A wrong priority shows up as a lost interrupt or a count one below the written value.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int ONESHOT_B = 0;
  localparam int WIDE_B    = 1;
  localparam int PRE_LO    = 2;
  localparam int PRE_HI    = 3;
  localparam int IE_B      = 5;
  localparam int MODE_B    = 6;
  localparam int EN_B      = 7;
  localparam logic [31:0] CTRL_MASK = 32'h0000_00EF;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       ie;
    logic [1:0] pre;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  function automatic ctrl_t to_ctrl(logic [31:0] w);
    ctrl_t c;
    c.en       = w[EN_B];
    c.periodic = w[MODE_B];
    c.ie       = w[IE_B];
    c.pre      = w[PRE_HI:PRE_LO];
    c.wide     = w[WIDE_B];
    c.oneshot  = w[ONESHOT_B];
    return c;
  endfunction

  function automatic logic [31:0] from_ctrl(ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[EN_B]          = c.en;
    w[MODE_B]        = c.periodic;
    w[IE_B]          = c.ie;
    w[PRE_HI:PRE_LO] = c.pre;
    w[WIDE_B]        = c.wide;
    w[ONESHOT_B]     = c.oneshot;
    return w;
  endfunction
endpackage

// File: rtl/dtimer_prescaler.sv
module dtimer_prescaler #(
  parameter int STEP = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] code_i,
  output logic       tick_o
);
  localparam int PRE_W = 2 * STEP;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  // code 3 reserved: same divisor as code 2
  always_comb begin
    unique case (code_i)
      2'd0:    lim = '0;
      2'd1:    lim = {{(PRE_W-STEP){1'b0}}, {STEP{1'b1}}};
      default: lim = '1;
    endcase
  end

  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || !run_i)    cnt_q <= '0;
    else if (tick_o)             cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dtimer_regs.sv
module dtimer_regs
  import dtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             load_we_i,
  input  logic             bgload_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] load_o,
  output logic             pre_chg_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  ctrl_t            ctrl_rst;
  logic [31:0]      wword;

  always_comb begin
    ctrl_rst    = '0;
    ctrl_rst.ie = 1'b1;
  end

  assign wword     = 32'(wdata_i);
  assign pre_chg_o = ctrl_we_i && (wword[PRE_HI:PRE_LO] != ctrl_q.pre);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= ctrl_rst;
      load_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q <= to_ctrl(wword);
    end else if (load_we_i || bgload_we_i) begin
      load_q <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
endmodule

// File: rtl/dtimer_count.sv
module dtimer_count
  import dtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctrl_we_i,
  input  logic             load_we_i,
  input  logic             intclr_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             wide_i,
  input  logic             periodic_i,
  input  logic             oneshot_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             ris_o
);
  localparam logic [CNT_W-1:0] NARROW_M = {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q, cnt_n, wmask, low, new_low, wlow;
  logic             run_q, run_n, ris_q, ris_set, tick_eff;

  assign wmask    = wide_i ? '1 : NARROW_M;
  assign low      = cnt_q & wmask;
  assign wlow     = wdata_i & wmask;
  assign tick_eff = tick_i && !ctrl_we_i && !load_we_i;

  always_comb begin
    cnt_n   = cnt_q;
    run_n   = run_q;
    ris_set = 1'b0;
    new_low = '0;
    if (ctrl_we_i) begin
      run_n = wdata_i[EN_B];
    end else if (load_we_i) begin
      cnt_n = wdata_i;
      if (periodic_i && (wlow == '0))   run_n = 1'b0;
      else if (en_i && (wlow != '0))    run_n = 1'b1;
    end else if (tick_eff) begin
      if (low == '0) begin
        new_low = periodic_i ? (load_i & wmask) : wmask;
      end else begin
        new_low = (low - 1'b1) & wmask;
        ris_set = (new_low == '0);
        if (ris_set && oneshot_i) run_n = 1'b0;
      end
      cnt_n = (cnt_q & ~wmask) | new_low;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      run_q <= 1'b0;
      ris_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      run_q <= run_n;
      ris_q <= ris_set | (ris_q & !intclr_we_i);
    end
  end

  assign count_o = cnt_q;
  assign run_o   = run_q;
  assign ris_o   = ris_q;
endmodule

// File: rtl/dtimer.sv
module dtimer
  import dtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16,
  parameter int STEP   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             load_we_i,
  input  logic             bgload_we_i,
  input  logic             intclr_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] load_o,
  output logic [31:0]      ctrl_o,
  output logic             ris_o,
  output logic             mis_o
);
  ctrl_t ctrl;
  logic  pre_chg, tick, run, ris;

  dtimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .ctrl_we_i, .load_we_i, .bgload_we_i, .wdata_i,
    .ctrl_o(ctrl), .load_o(load_o), .pre_chg_o(pre_chg)
  );

  dtimer_prescaler #(.STEP(STEP)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .clr_i(pre_chg), .code_i(ctrl.pre), .tick_o(tick)
  );

  dtimer_count #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .ctrl_we_i, .load_we_i, .intclr_we_i,
    .wdata_i, .load_i(load_o), .wide_i(ctrl.wide), .periodic_i(ctrl.periodic),
    .oneshot_i(ctrl.oneshot), .en_i(ctrl.en),
    .count_o(count_o), .run_o(run), .ris_o(ris)
  );

  assign ctrl_o = from_ctrl(ctrl);
  assign ris_o  = ris;
  assign mis_o  = ris & ctrl.ie;
endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic        load_we_i,
  input logic        bgload_we_i,
  input logic [31:0] wdata_i,
  input logic [31:0] count_o,
  input logic [31:0] load_o,
  input logic [31:0] ctrl_o,
  input logic        ris_o
);
  // R2
  ctrl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ctrl_o == ($past(wdata_i) & 32'h0000_00EF));

  // R7
  load_imm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_we_i && !ctrl_we_i) |=> (count_o == $past(wdata_i)) && (load_o == $past(wdata_i)));

  // R7
  bgload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bgload_we_i && !load_we_i && !ctrl_we_i) |=> load_o == $past(wdata_i));

  // R9
  ris_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ris_o) |-> (ctrl_o[1] ? (count_o == 32'd0) : (count_o[15:0] == 16'd0)));

  // R6
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[1] && !load_we_i && !ctrl_we_i) |=> $stable(count_o[31:16]));

  // R10
  oneshot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ris_o) && ctrl_o[0] && !load_we_i && !ctrl_we_i) |=> $stable(count_o));
endmodule

bind dtimer dtimer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .load_we_i(load_we_i),
  .bgload_we_i(bgload_we_i), .wdata_i(wdata_i), .count_o(count_o),
  .load_o(load_o), .ctrl_o(ctrl_o), .ris_o(ris_o)
);

// File: tb/sim_dtimer.sv
`timescale 1ns/1ps
module sim_dtimer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 0, load_we = 0, bg_we = 0, clr_we = 0;
  logic [31:0] wd = '0;
  logic [31:0] count_o, load_o, ctrl_o;
  logic        ris_o, mis_o;

  int    total = 0, bad = 0;
  bit    done = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  dtimer u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .load_we_i(load_we),
    .bgload_we_i(bg_we), .intclr_we_i(clr_we), .wdata_i(wd),
    .count_o(count_o), .load_o(load_o), .ctrl_o(ctrl_o), .ris_o(ris_o), .mis_o(mis_o)
  );

  // behavioural reference
  logic [31:0] m_ctrl, m_load, m_cnt, wm, low, nl;
  bit          m_run, m_ris, tick, setr;
  int          m_pre, npre, div;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 32'h20; m_load = 0; m_cnt = 32'hFFFF_FFFF;
      m_run = 0; m_ris = 0; m_pre = 0;
    end else begin
      div  = (m_ctrl[3:2] == 0) ? 1 : (m_ctrl[3:2] == 1) ? 16 : 256;
      tick = m_run && (m_pre == div - 1);
      wm   = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      setr = 0;
      if (ctrl_we && wd[3:2] != m_ctrl[3:2]) npre = 0;
      else if (!m_run || tick)               npre = 0;
      else                                   npre = m_pre + 1;
      if (ctrl_we) begin
        m_ctrl = wd & 32'hEF;
        m_run  = wd[7];
      end else if (load_we) begin
        m_load = wd; m_cnt = wd;
        low = wd & wm;
        if (m_ctrl[6] && low == 0)        m_run = 0;
        else if (m_ctrl[7] && low != 0)   m_run = 1;
      end else begin
        if (tick) begin
          low = m_cnt & wm;
          if (low == 0) nl = m_ctrl[6] ? (m_load & wm) : wm;
          else begin
            nl = (low - 1) & wm;
            if (nl == 0) begin setr = 1; if (m_ctrl[0]) m_run = 0; end
          end
          m_cnt = (m_cnt & ~wm) | nl;
        end
        if (bg_we) m_load = wd;
      end
      if (clr_we) m_ris = 0;
      if (setr)   m_ris = 1;
      m_pre = npre;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", phase, what, act, exp);
    end
  endtask

  task automatic eq(input string what, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, what, act, exp);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      eq("model count", count_o, m_cnt);
      eq("model load", load_o, m_load);
      eq("model ctrl", ctrl_o, m_ctrl);
      eq("model ris", {31'd0, ris_o}, {31'd0, m_ris});
      eq("model mis", {31'd0, mis_o}, {31'd0, m_ris & m_ctrl[5]});
    end
  end

  task automatic wr(input int kind, input logic [31:0] d);
    wd = d;
    case (kind)
      0: ctrl_we = 1;
      1: load_we = 1;
      2: bg_we = 1;
      default: clr_we = 1;
    endcase
    @(negedge clk);
    ctrl_we = 0; load_we = 0; bg_we = 0; clr_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  localparam int CTRL = 0, LOAD = 1, BGL = 2, CLR = 3;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL %s watchdog expired act=%h exp=%h", phase, 32'd1, 32'd0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    phase = "R1";
    eq("R1 ctrl", ctrl_o, 32'h20);
    eq("R1 load", load_o, 32'h0);
    eq("R1 count", count_o, 32'hFFFF_FFFF);
    eq("R1 ris/mis", {30'd0, ris_o, mis_o}, 32'd0);

    // R2 reserved bits dropped
    phase = "R2";
    wr(CTRL, 32'hFFFF_FF7F);
    eq("R2 ctrl mask", ctrl_o, 32'h6F);
    wr(CTRL, 32'h20);

    // R7 background vs immediate load
    phase = "R7";
    wr(BGL, 32'h1234);
    eq("R7 bgload load", load_o, 32'h1234);
    eq("R7 bgload count kept", count_o, 32'hFFFF_FFFF);
    wr(LOAD, 32'h5678);
    eq("R7 load count", count_o, 32'h5678);

    // R4 free wrap, R9 interrupt
    phase = "R4";
    wr(CTRL, 32'hA0);
    wr(LOAD, 32'h1);
    idle(2);
    eq("R4 wrap 16", count_o, 32'h0000_FFFF);
    eq("R9 ris set", {31'd0, ris_o}, 32'd1);
    eq("R9 mis set", {31'd0, mis_o}, 32'd1);

    // R12 tick discarded on load
    phase = "R12";
    wr(LOAD, 32'd10);
    eq("R12 load lands unmodified", count_o, 32'd10);

    // R6 upper half preserved
    phase = "R6";
    wr(LOAD, 32'hABCD_0002);
    idle(3);
    eq("R6 upper kept on wrap", count_o, 32'hABCD_FFFF);
    wr(CTRL, 32'h22);
    wr(LOAD, 32'h0001_0001);
    wr(CTRL, 32'hA2);
    idle(3);
    eq("R6 32-bit borrow", count_o, 32'h0000_FFFE);

    // R9 clear, masked, set wins
    phase = "R9";
    wr(CTRL, 32'h80);
    wr(CLR, 0);
    eq("R9 cleared", {31'd0, ris_o}, 32'd0);
    wr(LOAD, 32'd1);
    idle(2);
    eq("R9 ris ie off", {31'd0, ris_o}, 32'd1);
    eq("R9 mis ie off", {31'd0, mis_o}, 32'd0);
    wr(CLR, 0);
    wr(LOAD, 32'd2);
    idle(1);
    wr(CLR, 0);
    eq("R9 set wins over clear", {31'd0, ris_o}, 32'd1);

    // R5 periodic reload
    phase = "R5";
    wr(CTRL, 32'h60);
    wr(LOAD, 32'd3);
    wr(CTRL, 32'hE0);
    idle(4);
    eq("R5 reload", count_o, 32'd3);
    wr(BGL, 32'd5);
    idle(12);

    // R8 zero load stops, nonzero restarts
    phase = "R8";
    wr(LOAD, 32'd0);
    idle(5);
    eq("R8 zero load holds", count_o, 32'd0);
    wr(LOAD, 32'd4);
    idle(2);
    eq("R8 restarted", count_o, 32'd2);

    // R10 one-shot halt and revive
    phase = "R10";
    wr(CLR, 0);
    wr(CTRL, 32'hE1);
    wr(LOAD, 32'd3);
    idle(8);
    eq("R10 held at zero", count_o, 32'd0);
    eq("R10 ris", {31'd0, ris_o}, 32'd1);
    wr(CTRL, 32'hE1);
    idle(2);
    eq("R10 revived", count_o, 32'd2);
    idle(5);

    // R3 prescale 16 and reserved code
    phase = "R3";
    wr(CTRL, 32'h20);
    wr(LOAD, 32'd100);
    wr(CTRL, 32'hA4);
    idle(15);
    eq("R3 div16 before", count_o, 32'd100);
    idle(1);
    eq("R3 div16 step", count_o, 32'd99);
    wr(CTRL, 32'h2C);
    wr(LOAD, 32'd10);
    wr(CTRL, 32'hAC);
    idle(255);
    eq("R3 code3 before", count_o, 32'd10);
    idle(1);
    eq("R3 code3 step", count_o, 32'd9);

    // R11 divider restart on prescale change
    phase = "R11";
    wr(CTRL, 32'h24);
    wr(LOAD, 32'd50);
    wr(CTRL, 32'hA4);
    idle(10);
    wr(CTRL, 32'hA8);
    idle(255);
    eq("R11 no early step", count_o, 32'd50);
    idle(1);
    eq("R11 step after full period", count_o, 32'd49);
    wr(CTRL, 32'hAC);
    idle(300);

    finish_run();
  end
endmodule